// File: doc/BRIEF.md
# ADC Conversion Result Register with Overrun and DMA Request Control

This block sits between a multi-channel analog-to-digital converter and the rest of the chip. Each finished conversion arrives as a one-cycle done pulse with its data word. The block stores the word in a single readable result register and raises an end-of-conversion flag. It detects when a new result arrives before the previous one was consumed, and a policy bit then decides whether the old result survives or is replaced. The flags can be cleared by writing ones, and the interrupt line combines each flag with its own enable.

When DMA is enabled, each conversion raises a request line that the DMA controller answers with an acknowledge. An overrun withdraws the request and blocks further requests until software clears the overrun flag. In one-shot mode, a transfer-complete indication from the DMA controller stops requests until DMA enable is dropped and raised again. In circular mode, requests continue regardless of transfer-complete.

Top module: `adc_result_reg`

## Requirements
- R1: A `conv_done` pulse sets `eoc_flag` one cycle later, and `data_out` shows the new `conv_data` unless R4 applies.
- R2: A `data_rd` strobe or a `dma_ack` clears `eoc_flag` and `dma_req` at the next edge. A conversion in the same cycle as such a read is not an overrun: it loads its data and leaves `eoc_flag` set.
- R3: An overrun happens when `conv_done` arrives while `eoc_flag` is set and neither `data_rd` nor `dma_ack` is asserted. It sets `ovr_flag` under either overrun policy.
- R4: With `ovr_mode` = 0, the conversion that causes an overrun is discarded and `data_out` keeps the unread result.
- R5: With `ovr_mode` = 1, every conversion overwrites `data_out`, including one that causes an overrun.
- R6: With `dma_en` = 1, each accepted conversion raises `dma_req`. With `dma_en` = 0, `dma_req` is low from the next cycle on.
- R7: An overrun drops any pending `dma_req` and raises no request for the overrunning result. While `ovr_flag` is set, no request is raised.
- R8: With `dma_circ` = 0, a `dma_tc` while enabled stops all later requests. Requests resume only after `dma_en` has been low for at least one cycle.
- R9: With `dma_circ` = 1, `dma_tc` has no effect, and every accepted conversion raises a request.
- R10: A `flag_wr` strobe clears `eoc_flag` where `flag_wdata[0]` = 1 and clears `ovr_flag` where `flag_wdata[1]` = 1. Zero bits leave the flags unchanged. A flag being set in the same cycle wins over its clear.
- R11: `irq` = (`eoc_flag` & `eoc_ie`) | (`ovr_flag` & `ovr_ie`), combinationally.
- R12: Reset (`rst_n` low) clears `data_out`, both flags, `dma_req` and the one-shot stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| conv_data | input | DW | Result word of the finished conversion |
| data_rd | input | 1 | Software read strobe of the result register |
| data_out | output | DW | Result register contents |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 2 | Write-one-to-clear bits: [0] end-of-conversion, [1] overrun |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| ovr_mode | input | 1 | 0: keep old result on overrun, 1: overwrite |
| dma_en | input | 1 | DMA request enable |
| dma_circ | input | 1 | 0: one-shot DMA, 1: circular DMA |
| dma_ack | input | 1 | DMA controller has taken the result |
| dma_tc | input | 1 | DMA controller reports its last transfer |
| dma_req | output | 1 | DMA request |
| eoc_flag | output | 1 | End-of-conversion flag |
| ovr_flag | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a new conversion completing and the previous result being consumed, either by a read or by a DMA acknowledge. The bench drives `conv_done` together with `data_rd` while `eoc_flag` is set. It expects no overrun, the new data in the register, and the flag still set. It also drives a conversion together with a write-one clear of `eoc_flag` and expects the set to win. A last collision pairs `dma_ack` with `dma_tc`, which in one-shot mode must block the request of the conversion that follows.

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  input  logic          data_rd,
  output logic [DW-1:0] data_out,
  input  logic          flag_wr,
  input  logic [1:0]    flag_wdata,
  input  logic          eoc_ie,
  input  logic          ovr_ie,
  input  logic          ovr_mode,
  input  logic          dma_en,
  input  logic          dma_circ,
  input  logic          dma_ack,
  input  logic          dma_tc,
  output logic          dma_req,
  output logic          eoc_flag,
  output logic          ovr_flag,
  output logic          irq
);

  logic [DW-1:0] data_q;
  logic eoc_q, ovr_q, req_q, stop_q;

  wire consumed  = data_rd | dma_ack;
  wire overrun   = conv_done & eoc_q & ~consumed;
  wire keep_old  = overrun & ~ovr_mode;
  wire clr_eoc   = flag_wr & flag_wdata[0];
  wire clr_ovr   = flag_wr & flag_wdata[1];
  wire tc_oneshot = dma_en & dma_tc & ~dma_circ;
  wire blocked   = ovr_q | (stop_q & ~dma_circ) | tc_oneshot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      eoc_q  <= 1'b0;
      ovr_q  <= 1'b0;
      req_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (conv_done && !keep_old)
        data_q <= conv_data;

      if (conv_done)
        eoc_q <= 1'b1;
      else if (consumed || clr_eoc)
        eoc_q <= 1'b0;

      if (overrun)
        ovr_q <= 1'b1;
      else if (clr_ovr)
        ovr_q <= 1'b0;

      if (!dma_en)
        stop_q <= 1'b0;
      else if (tc_oneshot)
        stop_q <= 1'b1;

      if (!dma_en || overrun)
        req_q <= 1'b0;
      else if (conv_done && !blocked)
        req_q <= 1'b1;
      else if (consumed || tc_oneshot)
        req_q <= 1'b0;
    end
  end

  assign data_out = data_q;
  assign eoc_flag = eoc_q;
  assign ovr_flag = ovr_q;
  assign dma_req  = req_q;
  assign irq      = (eoc_q & eoc_ie) | (ovr_q & ovr_ie);

endmodule

// File: rtl/adc_result_reg_chk.sv
module adc_result_reg_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_done,
  input logic [DW-1:0] conv_data,
  input logic          data_rd,
  input logic [DW-1:0] data_out,
  input logic          ovr_mode,
  input logic          dma_en,
  input logic          dma_circ,
  input logic          dma_ack,
  input logic          dma_req,
  input logic          eoc_flag,
  input logic          ovr_flag
);

  a_r1_done_sets_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> eoc_flag);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd || dma_ack) && !conv_done |=> !eoc_flag && !dma_req);

  a_r3_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && eoc_flag && !data_rd && !dma_ack |=> ovr_flag);

  a_r4_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && eoc_flag && !data_rd && !dma_ack && !ovr_mode |=> $stable(data_out));

  a_r5_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && ovr_mode |=> data_out == $past(conv_data));

  a_r6_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dma_req);

  a_r7_ovr_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> !dma_req);

  a_r9_circular_req: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && dma_en && dma_circ && !ovr_flag && !(eoc_flag && !data_rd && !dma_ack)
    |=> dma_req);

endmodule

bind adc_result_reg adc_result_reg_chk #(.DW(DW)) chk_i (.*);

// File: tb/adc_result_reg_tb_top.sv
`timescale 1ns/1ps
module adc_result_reg_tb_top;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done = 0, data_rd = 0, flag_wr = 0, eoc_ie = 0, ovr_ie = 0;
  logic ovr_mode = 0, dma_en = 0, dma_circ = 0, dma_ack = 0, dma_tc = 0;
  logic [DW-1:0] conv_data = '0;
  logic [1:0] flag_wdata = '0;
  logic [DW-1:0] data_out;
  logic dma_req, eoc_flag, ovr_flag, irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  adc_result_reg #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .data_rd(data_rd), .data_out(data_out), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .eoc_ie(eoc_ie), .ovr_ie(ovr_ie), .ovr_mode(ovr_mode), .dma_en(dma_en),
    .dma_circ(dma_circ), .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_req(dma_req),
    .eoc_flag(eoc_flag), .ovr_flag(ovr_flag), .irq(irq)
  );

  typedef struct packed {
    logic cv; logic [11:0] d; logic rd, ack, tc, om, den, circ; logic [1:0] clr;
    logic [11:0] ed; logic ee, eo, er;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1,12'h011,0,0,0,0,0,0,2'd0,12'h011,1,0,0},  // R1
    '{0,12'h000,1,0,0,0,0,0,2'd0,12'h011,0,0,0},  // R2 read
    '{1,12'h022,0,0,0,0,0,0,2'd0,12'h022,1,0,0},
    '{1,12'h033,0,0,0,0,0,0,2'd0,12'h022,1,1,0},  // R3 R4 keep
    '{0,12'h000,0,0,0,0,0,0,2'd2,12'h022,1,0,0},  // R10 clear ovr
    '{1,12'h044,0,0,0,1,0,0,2'd0,12'h044,1,1,0},  // R5 overwrite
    '{0,12'h000,0,0,0,1,0,0,2'd3,12'h044,0,0,0},
    '{1,12'h055,0,0,0,0,0,0,2'd0,12'h055,1,0,0},
    '{1,12'h066,1,0,0,0,0,0,2'd0,12'h066,1,0,0},  // R2 read+conv
    '{0,12'h000,1,0,0,0,0,0,2'd0,12'h066,0,0,0},
    '{1,12'h077,0,0,0,0,1,0,2'd0,12'h077,1,0,1},  // R6
    '{0,12'h000,0,1,0,0,1,0,2'd0,12'h077,0,0,0},  // R2 ack
    '{1,12'h088,0,0,0,0,1,0,2'd0,12'h088,1,0,1},
    '{0,12'h000,0,1,1,0,1,0,2'd0,12'h088,0,0,0},  // R8 tc
    '{1,12'h099,0,0,0,0,1,0,2'd0,12'h099,1,0,0},  // R8 stopped
    '{0,12'h000,1,0,0,0,1,0,2'd0,12'h099,0,0,0},
    '{0,12'h000,0,0,0,0,0,0,2'd0,12'h099,0,0,0},  // R8 re-arm
    '{1,12'h0A1,0,0,0,0,1,0,2'd0,12'h0A1,1,0,1},
    '{1,12'h0A2,0,0,0,0,1,0,2'd0,12'h0A1,1,1,0},  // R7 withdraw
    '{0,12'h000,1,0,0,0,1,0,2'd0,12'h0A1,0,1,0},
    '{1,12'h0A3,0,0,0,0,1,0,2'd0,12'h0A3,1,1,0},  // R7 blocked
    '{0,12'h000,0,0,0,0,1,0,2'd3,12'h0A3,0,0,0},
    '{1,12'h0A4,0,0,0,0,1,0,2'd0,12'h0A4,1,0,1},
    '{0,12'h000,0,1,1,0,1,1,2'd0,12'h0A4,0,0,0},  // R9 tc ignored
    '{1,12'h0A5,0,0,0,0,1,1,2'd0,12'h0A5,1,0,1},
    '{0,12'h000,0,1,0,0,1,1,2'd0,12'h0A5,0,0,0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    conv_done = 0; data_rd = 0; dma_ack = 0; dma_tc = 0; flag_wr = 0; flag_wdata = 0;
  endtask

  initial begin
    #160000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 data", 32'(data_out), 0);
    chk("R12 eoc", 32'(eoc_flag), 0);
    chk("R12 ovr", 32'(ovr_flag), 0);
    chk("R12 req", 32'(dma_req), 0);
    rst_n = 1;
    eoc_ie = 1; ovr_ie = 1;
    for (int i = 0; i < NV; i++) begin
      conv_done = TBL[i].cv; conv_data = TBL[i].d; data_rd = TBL[i].rd;
      dma_ack = TBL[i].ack; dma_tc = TBL[i].tc; ovr_mode = TBL[i].om;
      dma_en = TBL[i].den; dma_circ = TBL[i].circ;
      flag_wr = |TBL[i].clr; flag_wdata = TBL[i].clr;
      @(negedge clk);
      chk("R1/R4/R5 data", 32'(data_out), 32'(TBL[i].ed));
      chk("R1/R2 eoc", 32'(eoc_flag), 32'(TBL[i].ee));
      chk("R3 ovr", 32'(ovr_flag), 32'(TBL[i].eo));
      chk("R6/R7/R8/R9 req", 32'(dma_req), 32'(TBL[i].er));
      chk("R11 irq", 32'(irq), 32'(TBL[i].ee | TBL[i].eo));
    end

    idle(); dma_en = 0; dma_circ = 0; ovr_mode = 0;
    conv_done = 1; conv_data = 12'h0B1;
    @(negedge clk); idle();
    flag_wr = 1; flag_wdata = 2'b00;
    @(negedge clk); idle();
    chk("R10 write zero keeps eoc", 32'(eoc_flag), 1);
    conv_done = 1; conv_data = 12'h0B2;
    @(negedge clk); idle();
    chk("R4 data kept", 32'(data_out), 12'h0B1);
    flag_wr = 1; flag_wdata = 2'b00;
    @(negedge clk); idle();
    chk("R10 write zero keeps ovr", 32'(ovr_flag), 1);
    chk("R6 no req when disabled", 32'(dma_req), 0);
    eoc_ie = 0; ovr_ie = 0; #1;
    chk("R11 masked", 32'(irq), 0);
    eoc_ie = 1; #1;
    chk("R11 eoc source", 32'(irq), 1);
    flag_wr = 1; flag_wdata = 2'b01;
    @(negedge clk); idle();
    chk("R10 eoc cleared", 32'(eoc_flag), 0);
    chk("R10 ovr untouched", 32'(ovr_flag), 1);
    #1 chk("R11 eoc cleared no irq", 32'(irq), 0);
    ovr_ie = 1; #1;
    chk("R11 ovr source", 32'(irq), 1);
    conv_done = 1; conv_data = 12'h0C3; flag_wr = 1; flag_wdata = 2'b01;
    @(negedge clk); idle();
    chk("R10 set wins over clear", 32'(eoc_flag), 1);
    chk("R1 data", 32'(data_out), 12'h0C3);
    rst_n = 0;
    @(negedge clk);
    chk("R12 reset data", 32'(data_out), 0);
    chk("R12 reset flags", 32'({eoc_flag, ovr_flag, dma_req}), 0);
    rst_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule